// File: doc/BRIEF.md
# Debounced Event Trigger Detector

This block is the front end of one interrupt source. It takes an asynchronous digital input and passes it through a two-flop synchronizer. It then accepts a change of level only after the new level has held for a programmable number of timebase ticks. When it accepts a change, it updates a filtered level output, which serves as the live sense bit. In the same cycle it may raise a one-clock event pulse for a downstream interrupt latch.

A two-bit mode selects which transitions raise events: rising, falling, both, or none. The filtered level follows the input whatever the mode is. Rising and falling transitions each have their own debounce length and their own tick rate. The rate is either a fast tick, for sub-millisecond intervals, or a slow tick, for millisecond intervals. A length of zero bypasses the filter.

Top module: `edge_event_filter`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `lvl_out` is 0 and `evt_pulse` is 0.
- R2: The input reaches the filter through two flops. With a zero length for the pending direction, `lvl_out` takes the new value on the third rising clock edge after `din_async` changes, and not earlier.
- R3: With a nonzero length N for the pending direction, `lvl_out` changes on the Nth tick of the selected rate counted while the synchronized input differs from `lvl_out`. Any cycle in which the synchronized input equals `lvl_out` clears the count.
- R4: `evt_pulse` is high for exactly one clock, in the same cycle in which `lvl_out` changes, provided the mode allows that direction.
- R5: A length of 0 for a direction qualifies a change in that direction without waiting for any tick.
- R6: `cfg_mode` bit 0 enables events on a 0-to-1 change and bit 1 enables events on a 1-to-0 change: 2'b01 is rising only, 2'b10 is falling only, 2'b11 is both, and 2'b00 gives no events.
- R7: A 0-to-1 change uses `cfg_rise_len` and `cfg_rise_fast`. A 1-to-0 change uses `cfg_fall_len` and `cfg_fall_fast`.
- R8: `lvl_out` follows a qualified change even when the mode disables events for that direction.
- R9: The fast tick occurs every FAST_DIV clocks and the slow tick every SLOW_DIV clocks. Both run freely from reset. A `cfg_*_fast` value of 1 selects the fast tick and 0 selects the slow tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_async | input | 1 | Raw asynchronous input |
| cfg_mode | input | 2 | Event direction enables (bit 0 rising, bit 1 falling) |
| cfg_rise_len | input | CNT_W | Ticks needed to accept a 0-to-1 change (0 = bypass) |
| cfg_rise_fast | input | 1 | Tick rate for 0-to-1 changes (1 = fast, 0 = slow) |
| cfg_fall_len | input | CNT_W | Ticks needed to accept a 1-to-0 change (0 = bypass) |
| cfg_fall_fast | input | 1 | Tick rate for 1-to-0 changes (1 = fast, 0 = slow) |
| evt_pulse | output | 1 | One-clock event pulse |
| lvl_out | output | 1 | Filtered level (sense bit) |

## Verification
Two things can land in the same cycle: qualification completes on a tick edge, and the synchronized input returns to the old level. Only the value sampled at that edge decides whether the change is accepted or the count is cleared. The bench provokes this with long runs of input pulses of random length, using fast ticks and short lengths while modes and rates keep changing. A behavioural model counts ticks in plain integers and is compared with `lvl_out` and `evt_pulse` on every clock. Directed phases cover glitch restarts, the zero-length bypass latency, and each mode setting.

// File: rtl/evtdb_pkg.sv
package evtdb_pkg;
    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/evtdb_tick.sv
module evtdb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.cnt == LAST);

    generate
        if (DIV > 1) begin : g_chk
            // R9: ticks are isolated single-cycle strobes
            a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/evtdb_sync.sv
module evtdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

    // R2: the last stage carries the previous cycle's value of the stage before it
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q[STAGES-1] == $past(sh_q[STAGES-2]));
endmodule

// File: rtl/evtdb_qual.sv
module evtdb_qual
    import evtdb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sin,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] rise_len,
    input  logic             rise_fast,
    input  logic [CNT_W-1:0] fall_len,
    input  logic             fall_fast,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic             level,
    output logic             evt
);
    typedef struct packed {
        logic             level;
        logic             evt;
        logic [CNT_W-1:0] cnt;
    } qual_st_t;

    qual_st_t         st_d, st_q;
    logic             going_up;
    logic [CNT_W-1:0] len;
    logic             tk;
    logic             allow;
    logic [CNT_W:0]   nxt;
    trig_mode_e       tmode;

    always_comb begin
        tmode    = trig_mode_e'(mode);
        going_up = ~st_q.level;
        len      = going_up ? rise_len : fall_len;
        tk       = (going_up ? rise_fast : fall_fast) ? tick_fast : tick_slow;
        allow    = going_up ? (tmode == TRIG_RISE || tmode == TRIG_BOTH)
                            : (tmode == TRIG_FALL || tmode == TRIG_BOTH);
        nxt      = {1'b0, st_q.cnt} + 1'b1;

        st_d     = st_q;
        st_d.evt = 1'b0;
        if (sin == st_q.level) begin
            st_d.cnt = '0;
        end else if (len == '0 || (tk && nxt >= {1'b0, len})) begin
            st_d.level = sin;
            st_d.cnt   = '0;
            st_d.evt   = allow;
        end else if (tk) begin
            st_d.cnt = nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign evt   = st_q.evt;

    // R4, R8: an event only accompanies a change of the filtered level
    a_r4_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> (st_q.level != $past(st_q.level)));
    // R3: a matching input holds the level and clears the count
    a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sin == st_q.level) |=> ($stable(st_q.level) && st_q.cnt == '0));
    // R6: rising events only when bit 0 of the mode was set
    a_r6_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.evt && st_q.level) |-> $past(mode[0]));
    // R6: falling events only when bit 1 of the mode was set
    a_r6_fall_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.evt && !st_q.level) |-> $past(mode[1]));
endmodule

// File: rtl/edge_event_filter.sv
module edge_event_filter #(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 16,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_async,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_rise_len,
    input  logic             cfg_rise_fast,
    input  logic [CNT_W-1:0] cfg_fall_len,
    input  logic             cfg_fall_fast,
    output logic             evt_pulse,
    output logic             lvl_out
);
    localparam int N_RATES = 2;

    logic [N_RATES-1:0] ticks;
    logic               sin;

    generate
        for (genvar g = 0; g < N_RATES; g++) begin : g_tick
            localparam int D = (g == 0) ? FAST_DIV : SLOW_DIV;
            evtdb_tick #(.DIV(D)) u_tick (
                .clk  (clk),
                .rst_n(rst_n),
                .tick (ticks[g])
            );
        end
    endgenerate

    evtdb_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din_async),
        .dout (sin)
    );

    evtdb_qual #(.CNT_W(CNT_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sin      (sin),
        .mode     (cfg_mode),
        .rise_len (cfg_rise_len),
        .rise_fast(cfg_rise_fast),
        .fall_len (cfg_fall_len),
        .fall_fast(cfg_fall_fast),
        .tick_fast(ticks[0]),
        .tick_slow(ticks[1]),
        .level    (lvl_out),
        .evt      (evt_pulse)
    );
endmodule

// File: tb/test_edge_event_filter.sv
`timescale 1ns/1ps
module test_edge_event_filter;
    localparam int CNT_W    = 8;
    localparam int FAST_DIV = 4;
    localparam int SLOW_DIV = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             din_async = 1'b0;
    logic [1:0]       cfg_mode = 2'b11;
    logic [CNT_W-1:0] cfg_rise_len = 8'd3;
    logic             cfg_rise_fast = 1'b0;
    logic [CNT_W-1:0] cfg_fall_len = 8'd2;
    logic             cfg_fall_fast = 1'b1;
    logic             evt_pulse;
    logic             lvl_out;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    int base;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_event_filter #(.CNT_W(CNT_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_edge_event_filter (
        .clk(clk), .rst_n(rst_n), .din_async(din_async), .cfg_mode(cfg_mode),
        .cfg_rise_len(cfg_rise_len), .cfg_rise_fast(cfg_rise_fast),
        .cfg_fall_len(cfg_fall_len), .cfg_fall_fast(cfg_fall_fast),
        .evt_pulse(evt_pulse), .lvl_out(lvl_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference: integer tick phases and a pending-change counter
    int m_s1, m_s2, m_lvl, m_evt, m_cnt, m_fc, m_sc;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_evt = 0; m_cnt = 0; m_fc = 0; m_sc = 0;
        end else begin
            int  len;
            bit  up, fast, tk;
            up   = (m_lvl == 0);
            len  = up ? int'(cfg_rise_len) : int'(cfg_fall_len);
            fast = up ? cfg_rise_fast : cfg_fall_fast;
            tk   = fast ? (m_fc == FAST_DIV - 1) : (m_sc == SLOW_DIV - 1);
            m_evt = 0;
            if (m_s2 == m_lvl) m_cnt = 0;
            else if (len == 0 || (tk && m_cnt + 1 >= len)) begin
                m_lvl = m_s2;
                m_cnt = 0;
                m_evt = up ? int'(cfg_mode[0]) : int'(cfg_mode[1]);
            end else if (tk) m_cnt = m_cnt + 1;
            m_s2 = m_s1;
            m_s1 = int'(din_async);
            m_fc = (m_fc + 1) % FAST_DIV;
            m_sc = (m_sc + 1) % SLOW_DIV;
        end
        if (rst_n && evt_pulse) ev_cnt++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 level vs model", int'(lvl_out), m_lvl);
            check("R4 event vs model", int'(evt_pulse), m_evt);
        end
    end

    initial begin
        cyc(5);
        check("R1 reset level", int'(lvl_out), 0);
        check("R1 reset event", int'(evt_pulse), 0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 first cycle level", int'(lvl_out), 0);
        cyc(9);

        // slow rising qualification, length 3
        base = ev_cnt;
        din_async = 1'b1;
        cyc(20);
        check("R3 slow rise not early", int'(lvl_out), 0);
        cyc(60);
        check("R3 slow rise accepted", int'(lvl_out), 1);
        check("R4 one rising event", ev_cnt - base, 1);

        // glitches shorter than the fall qualification keep restarting
        base = ev_cnt;
        repeat (10) begin
            din_async = 1'b0; cyc(3);
            din_async = 1'b1; cyc(2);
        end
        cyc(10);
        check("R3 glitches rejected level", int'(lvl_out), 1);
        check("R3 glitches rejected events", ev_cnt - base, 0);

        // zero length bypass latency
        cfg_fall_len = '0;
        din_async = 1'b0;
        cyc(2);
        check("R2 not before third edge", int'(lvl_out), 1);
        cyc(1);
        check("R5 bypass level", int'(lvl_out), 0);
        check("R5 bypass event", int'(evt_pulse), 1);
        cyc(5);

        // falling only
        cfg_mode = 2'b10; cfg_rise_len = '0;
        base = ev_cnt;
        din_async = 1'b1; cyc(6);
        check("R8 level follows rise in fall mode", int'(lvl_out), 1);
        check("R6 no rising event in fall mode", ev_cnt - base, 0);
        din_async = 1'b0; cyc(6);
        check("R6 falling event in fall mode", ev_cnt - base, 1);

        // rising only
        cfg_mode = 2'b01;
        base = ev_cnt;
        din_async = 1'b1; cyc(6);
        check("R6 rising event in rise mode", ev_cnt - base, 1);
        din_async = 1'b0; cyc(6);
        check("R8 level follows fall in rise mode", int'(lvl_out), 0);
        check("R6 no falling event in rise mode", ev_cnt - base, 1);

        // no events
        cfg_mode = 2'b00;
        base = ev_cnt;
        repeat (3) begin
            din_async = 1'b1; cyc(6);
            din_async = 1'b0; cyc(6);
        end
        din_async = 1'b1; cyc(6);
        check("R6 mode none gives no events", ev_cnt - base, 0);
        check("R8 mode none level", int'(lvl_out), 1);
        din_async = 1'b0; cyc(6);

        // per-direction length and rate
        cfg_mode = 2'b11;
        cfg_rise_len = 8'd3; cfg_rise_fast = 1'b1;
        cfg_fall_len = 8'd3; cfg_fall_fast = 1'b0;
        din_async = 1'b1; cyc(16);
        check("R9 fast rise within 16 cycles", int'(lvl_out), 1);
        din_async = 1'b0; cyc(16);
        check("R7 slow fall still pending", int'(lvl_out), 1);
        cyc(60);
        check("R7 slow fall accepted", int'(lvl_out), 0);

        // random pulses: coincidence of qualifying tick and return to old level
        repeat (300) begin
            cfg_mode      = 2'($urandom_range(0, 3));
            cfg_rise_len  = 8'($urandom_range(0, 3));
            cfg_fall_len  = 8'($urandom_range(0, 3));
            cfg_rise_fast = 1'($urandom_range(0, 1));
            cfg_fall_fast = 1'($urandom_range(0, 1));
            din_async     = ~din_async;
            cyc($urandom_range(1, 12));
        end
        cyc(60);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule